// File: doc/BRIEF.md
# Calibration clock and boost timer

The block derives a slow calibration tick from a fast reference clock and uses that tick to time a charge-boost window for an external filter capacitor. A programmable 6-bit divider turns the reference clock into a stream of single-cycle tick pulses. With a 32 MHz reference and a divider value of 16, for example, the ticks arrive at the nominal 2 MHz calibration rate.

A start strobe opens the boost window. The boost output then stays high for a programmed number of calibration periods and drops on its own, with a one-cycle done pulse at that moment. A programmed count of zero disables the automatic window. In that case the boost output simply follows a manual control bit, which software must hold low for normal receive operation.

Top module: `cal_boost_timer`

## Requirements
- R1: While reset is high, and on the first cycle after it, cal_tick, boost and boost_done are all low.
- R2: With divider value D held constant, cal_tick is high for one cycle out of every max(D,1) cycles. D = 0 and D = 1 both divide by 1, so cal_tick is high on every cycle.
- R3: With a nonzero boost_count, a start strobe sampled at a clock edge drives boost high from that edge on.
- R4: After the start edge, boost stays high until the clock edge that samples the boost_count-th high cal_tick, counted from the edge after the start edge. It is low from that edge on. A tick sampled at the same edge as the start is not counted.
- R5: boost_done is high for exactly one cycle, starting at the edge where boost falls at the end of an automatic window. It is low at all other times.
- R6: A start strobe while a window is running reloads the count. Boost stays high, and the window ends boost_count ticks after the new start edge.
- R7: With boost_count = 0, boost takes the value manual_boost had at the previous edge (1 = on, 0 = off). Start strobes have no effect, and boost_done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| cal_div_value | input | 6 | Calibration divider value (0 and 1 mean divide by 1) |
| boost_count | input | 6 | Boost window length in calibration periods; 0 selects manual mode |
| manual_boost | input | 1 | Boost level used in manual mode |
| start | input | 1 | One-cycle strobe that opens or restarts the boost window |
| cal_tick | output | 1 | Calibration tick, one cycle wide |
| boost | output | 1 | Capacitor boost enable |
| boost_done | output | 1 | One-cycle pulse when an automatic window ends |

## Verification
The assertions assume that the divider value and the boost count stay constant while a tick interval or a boost window is being measured. The only exception is the tick-width check, which excuses a cycle in which the divider value changes. The stimulus changes these fields only between measurements, at the falling clock edge. Before it measures tick spacing after a new divider value, it waits for two ticks so the divider counter can settle. Start strobes last one cycle. The restart case issues its second strobe while the window is open.

// File: rtl/cbt_pkg.sv
package cbt_pkg;
  localparam int DIV_W_DEF = 6;
  localparam int CNT_W_DEF = 6;

  typedef enum logic [1:0] {
    BST_IDLE   = 2'd0,
    BST_RUN    = 2'd1,
    BST_MANUAL = 2'd2
  } boost_state_e;
endpackage

// File: rtl/cbt_divider.sv
module cbt_divider #(
  parameter int DIV_W = cbt_pkg::DIV_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] eff_div;
  logic             wrap;

  // values 0 and 1 both select divide-by-1
  assign eff_div = (div_val < DIV_W'(2)) ? DIV_W'(1) : div_val;
  // >= also covers a divider value lowered while the count is past it
  assign wrap    = (cnt_q >= eff_div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else if (wrap) begin
      cnt_q <= '0;
      tick  <= 1'b1;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
      tick  <= 1'b0;
    end
  end

  // R2
  tick_width_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && eff_div > DIV_W'(1) && $stable(div_val)) |=> (!tick || !$stable(div_val)));

  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    $stable(div_val) |-> (cnt_q < eff_div));
endmodule

// File: rtl/cbt_timer.sv
module cbt_timer #(
  parameter int CNT_W = cbt_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [CNT_W-1:0] count,
  input  logic             manual,
  input  logic             start,
  output logic             boost,
  output logic             done
);
  import cbt_pkg::*;

  boost_state_e     state_q;
  logic [CNT_W-1:0] remain_q;
  logic             manual_mode;

  assign manual_mode = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= BST_IDLE;
      remain_q <= '0;
      boost    <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (manual_mode) begin
        state_q  <= BST_MANUAL;
        remain_q <= '0;
        boost    <= manual;
      end else begin
        case (state_q)
          BST_RUN: begin
            if (start) begin
              remain_q <= count;
              boost    <= 1'b1;
            end else if (tick) begin
              if (remain_q == CNT_W'(1)) begin
                state_q  <= BST_IDLE;
                remain_q <= '0;
                boost    <= 1'b0;
                done     <= 1'b1;
              end else begin
                remain_q <= remain_q - CNT_W'(1);
              end
            end
          end
          default: begin
            if (start) begin
              state_q  <= BST_RUN;
              remain_q <= count;
              boost    <= 1'b1;
            end else begin
              state_q  <= BST_IDLE;
              boost    <= 1'b0;
            end
          end
        endcase
      end
    end
  end

  // R3
  boost_rise_chk: assert property (@(posedge clk) disable iff (rst)
    (start && !manual_mode) |=> boost);

  // R5
  done_fall_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> $fell(boost));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7
  manual_follow_chk: assert property (@(posedge clk) disable iff (rst)
    manual_mode |=> (boost == $past(manual) && !done));

  // R4
  remain_live_chk: assert property (@(posedge clk) disable iff (rst)
    (state_q == BST_RUN) |-> (remain_q != '0 && boost));
endmodule

// File: rtl/cal_boost_timer.sv
module cal_boost_timer #(
  parameter int DIV_W = cbt_pkg::DIV_W_DEF,
  parameter int CNT_W = cbt_pkg::CNT_W_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] cal_div_value,
  input  logic [CNT_W-1:0] boost_count,
  input  logic             manual_boost,
  input  logic             start,
  output logic             cal_tick,
  output logic             boost,
  output logic             boost_done
);
  logic tick_w;

  cbt_divider #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .div_val (cal_div_value),
    .tick    (tick_w)
  );

  cbt_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick_w),
    .count  (boost_count),
    .manual (manual_boost),
    .start  (start),
    .boost  (boost),
    .done   (boost_done)
  );

  assign cal_tick = tick_w;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!cal_tick && !boost && !boost_done));
endmodule

// File: tb/cal_boost_timer_test.sv
module cal_boost_timer_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cal_div_value = 6'd2;
  logic [5:0] boost_count = 6'd0;
  logic       manual_boost = 1'b0;
  logic       start = 1'b0;
  logic       cal_tick, boost, boost_done;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cal_boost_timer uut (
    .clk(clk), .rst(rst), .cal_div_value(cal_div_value),
    .boost_count(boost_count), .manual_boost(manual_boost), .start(start),
    .cal_tick(cal_tick), .boost(boost), .boost_done(boost_done)
  );

  task automatic check(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // wait until cal_tick is seen high at a falling edge
  task automatic wait_tick();
    while (cal_tick !== 1'b1) @(negedge clk);
  endtask

  // after a start has been sampled, follow the window tick by tick
  task automatic follow_window(input int t, input string req);
    int seen = 0;
    int bad = 0;
    while (seen < t) begin
      if (boost !== 1'b1 || boost_done !== 1'b0) bad++;
      if (cal_tick === 1'b1) seen++;
      @(negedge clk);
    end
    check({req, " boost high through window"}, bad, 0);
    check({req, " boost low at end"}, int'(boost), 0);
    check("R5 done at end", int'(boost_done), 1);
    @(negedge clk);
    check("R5 done one cycle", int'(boost_done), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tick in reset", int'(cal_tick), 0);
    check("R1 boost in reset", int'(boost), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 tick after reset", int'(cal_tick), 0);
    check("R1 boost after reset", int'(boost), 0);
    check("R1 done after reset", int'(boost_done), 0);

    // R2: sweep every divider value
    for (int d = 0; d < 64; d++) begin
      int gap;
      int exp;
      cal_div_value = 6'(d);
      @(negedge clk);
      wait_tick(); @(negedge clk);
      wait_tick(); @(negedge clk);
      gap = 1;
      while (cal_tick !== 1'b1) begin gap++; @(negedge clk); end
      exp = (d < 2) ? 1 : d;
      check($sformatf("R2 tick period div=%0d", d), gap, exp);
    end
    cal_div_value = 6'd16;
    wait_tick(); @(negedge clk);
    begin
      int gap = 1;
      while (cal_tick !== 1'b1) begin gap++; @(negedge clk); end
      check("R2 nominal div 16", gap, 16);
    end

    // R3, R4, R5: sweep boost counts over two divider values
    for (int dv = 1; dv <= 3; dv += 2) begin
      cal_div_value = 6'(dv);
      for (int t = 1; t < 64; t++) begin
        boost_count = 6'(t);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check($sformatf("R3 boost after start t=%0d", t), int'(boost), 1);
        follow_window(t, $sformatf("R4 div=%0d t=%0d", dv, t));
      end
    end

    // R6: restart during a window
    cal_div_value = 6'd4;
    boost_count = 6'd10;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int seen = 0;
      while (seen < 6) begin
        if (cal_tick === 1'b1) seen++;
        @(negedge clk);
      end
    end
    check("R6 boost before restart", int'(boost), 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R6 boost after restart", int'(boost), 1);
    follow_window(10, "R6 restarted");

    // R7: manual mode
    boost_count = 6'd0;
    manual_boost = 1'b1;
    @(negedge clk);
    check("R7 manual on", int'(boost), 1);
    manual_boost = 1'b0;
    @(negedge clk);
    check("R7 manual off", int'(boost), 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int bad = 0;
      for (int i = 0; i < 20; i++) begin
        if (boost !== 1'b0 || boost_done !== 1'b0) bad++;
        @(negedge clk);
      end
      check("R7 start ignored in manual", bad, 0);
    end
    manual_boost = 1'b1;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 manual on with start", int'(boost), 1);
    check("R7 no done in manual", int'(boost_done), 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule